// File: doc/BRIEF.md
# Hiccup Fault Supervisor with Digital Soft-Start

This block is the digital fault manager of a multi-output power controller. It takes level flags from external comparators and decides when the outputs must be held off. The flags are over-current on the switching output, under-voltage on each linear output and over-voltage on the switching output. A 10-bit ramp counter advances on an enable tick and takes the place of an analog soft-start capacitor. The block drives one shared inhibit line, the ramp value, a fault flag and a crowbar request for the low-side switch.

An over-current trip inhibits every output and starts a hiccup. The ramp is discharged, recharged, and each completed discharge event advances a retry counter. The third retry latches a permanent fault. Under-voltage on a linear output is ignored until the ramp has reached full scale, so the outputs can come up without a false trip. One over-voltage event latches the fault at once and requests the crowbar. Only power-on reset clears the retry counter, the fault and the crowbar.

There is no data stream here. Every pin is a plain level control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `hiccup_supervisor`

## Requirements
- R1: While power-on reset (`por_n` low) is asserted, `inhibit_o`, `fault_o` and `crowbar_o` are 0 and `ramp_o` is 0.
- R2: Outside discharge, the ramp rises by one on each rising edge where `tick_i` is 1. It holds when `tick_i` is 0 and saturates at full scale, 1023.
- R3: Every comparator flag passes through a two-flop synchronizer. An over-current flag driven between edges raises `inhibit_o` on the third rising edge after it, and not before.
- R4: A linear under-voltage flag has no effect on `inhibit_o` while the ramp is below full scale.
- R5: With the ramp at full scale, any linear under-voltage flag acts as an over-current trip: `inhibit_o` rises on the third edge.
- R6: A trip taken while the retry count is zero discharges the ramp at once. The ramp reads 0 two edges after `inhibit_o` rises, given `tick_i` high.
- R7: A trip taken while the retry count is nonzero lets the ramp keep rising to full scale with `inhibit_o` high. The count then advances and the ramp discharges.
- R8: After the ramp is at zero, a new charge cycle begins on the next edge. The trip latch clears, so `inhibit_o` falls if no trip is pending, and the ramp counts up again from 0.
- R9: When the retry count reaches three, `fault_o` rises on the edge the third retry is taken. From then on `inhibit_o` stays 1, the ramp goes to 0 and stays there, and `crowbar_o` stays 0.
- R10: An over-voltage flag raises both `fault_o` and `crowbar_o` on the third edge after it, with no retry counting. The ramp is at 0 one edge later.
- R11: The retry count survives recovery from a trip. The fault and crowbar persist after every flag is removed. Only power-on reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | Ramp enable tick, one step per cycle where high |
| oc_flag_i | input | 1 | Over-current flag, switching output (asynchronous) |
| uv_flag_i | input | 3 | Under-voltage flags, one per linear output (asynchronous) |
| ov_flag_i | input | 1 | Over-voltage flag, switching output (asynchronous) |
| inhibit_o | output | 1 | Shared inhibit for all outputs |
| ramp_o | output | 10 | Soft-start ramp value |
| fault_o | output | 1 | Latched fault |
| crowbar_o | output | 1 | Low-side switch turn-on request |

## Verification
Each flag reaches its latch on the third rising edge after it is driven: two synchronizer edges plus the latch edge. The inhibit, fault and crowbar results are therefore due at edge three. A retry discharge follows on the next edge and shows as a zero ramp one edge after that, and the restart comes one edge later again. The bench drives every input on a falling edge and advances a counted number of rising edges. It samples on the following falling edge and checks the edge just before each due edge as well as the due edge, so that early and late responses are both caught. The long full-scale waits poll the ramp one edge at a time and then resume exact edge counting from the first edge at which the ramp reads full scale.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [0:0] {
    PH_CHARGE    = 1'b0,
    PH_DISCHARGE = 1'b1
  } ph_t;

endpackage

// File: rtl/hiccup_sync.sv
module hiccup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/hiccup_ramp.sv
module hiccup_ramp #(
  parameter int RAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              discharge,
  output logic [RAMP_W-1:0] ramp,
  output logic              at_full,
  output logic              at_zero
);

  localparam logic [RAMP_W-1:0] FULL = '1;
  localparam logic [RAMP_W-1:0] ONE  = {{(RAMP_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp <= '0;
    end else if (tick) begin
      if (discharge) begin
        ramp <= '0;
      end else if (ramp != FULL) begin
        ramp <= ramp + ONE;
      end
    end
  end

  assign at_full = (ramp == FULL);
  assign at_zero = (ramp == '0);

  AST_RAMP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (at_full && !discharge) |=> at_full); // R2
  AST_RAMP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ramp)); // R2
  AST_RAMP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !discharge && !at_full) |=> (ramp == $past(ramp) + ONE)); // R2
  AST_RAMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && discharge) |=> at_zero); // R6

endmodule

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl
  import hiccup_pkg::*;
#(
  parameter int NUM_LIN = 3,
  parameter int RETRIES = 3,
  localparam int CW     = $clog2(RETRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oc_s,
  input  logic [NUM_LIN-1:0] uv_s,
  input  logic               ov_s,
  input  logic               ramp_full,
  input  logic               ramp_zero,
  output ph_t                phase,
  output logic               inhibit,
  output logic               fault,
  output logic               crowbar
);

  logic          oc_q;
  logic [CW-1:0] retries;
  logic          charging;
  logic          trip;
  logic          retry_evt;
  logic          restart;
  logic          last_retry;

  assign charging   = (phase == PH_CHARGE);
  // under-voltage only counts once the ramp has reached full scale
  assign trip       = charging & (oc_s | ((|uv_s) & ramp_full));
  // first retry discharges at once; later ones wait for full scale
  assign retry_evt  = charging & oc_q & ((retries == '0) | ramp_full);
  assign restart    = !charging & ramp_zero & !fault & !ov_s;
  assign last_retry = (retries == CW'(RETRIES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_CHARGE;
      oc_q    <= 1'b0;
      retries <= '0;
      fault   <= 1'b0;
      crowbar <= 1'b0;
    end else begin
      if (ov_s) begin
        fault   <= 1'b1;
        crowbar <= 1'b1;
        phase   <= PH_DISCHARGE;
      end
      if (retry_evt) begin
        phase   <= PH_DISCHARGE;
        retries <= retries + CW'(1);
        if (last_retry) begin
          fault <= 1'b1;
        end
      end else if (restart) begin
        phase <= PH_CHARGE;
        oc_q  <= 1'b0;
      end else if (trip) begin
        oc_q <= 1'b1;
      end
    end
  end

  assign inhibit = oc_q | fault;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R11
  AST_CROWBAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar |=> crowbar); // R11
  AST_CROWBAR_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar |-> fault); // R10
  AST_OV_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    ov_s |=> (fault && crowbar)); // R10
  AST_UV_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(oc_q) && !$past(oc_s)) |-> $past(ramp_full)); // R4
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    retries <= CW'(RETRIES)); // R9

endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
  import hiccup_pkg::*;
#(
  parameter int RAMP_W  = 10,
  parameter int NUM_LIN = 3,
  parameter int RETRIES = 3,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               tick_i,
  input  logic               oc_flag_i,
  input  logic [NUM_LIN-1:0] uv_flag_i,
  input  logic               ov_flag_i,
  output logic               inhibit_o,
  output logic [RAMP_W-1:0]  ramp_o,
  output logic               fault_o,
  output logic               crowbar_o
);

  localparam int FLAG_W = NUM_LIN + 2;

  logic [FLAG_W-1:0]  raw_flags;
  logic [FLAG_W-1:0]  sync_flags;
  logic               oc_s;
  logic               ov_s;
  logic [NUM_LIN-1:0] uv_s;
  logic               ramp_full;
  logic               ramp_zero;
  ph_t                phase;

  assign raw_flags = {ov_flag_i, uv_flag_i, oc_flag_i};

  hiccup_sync #(
    .W      (FLAG_W),
    .STAGES (SYNC_N)
  ) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     (raw_flags),
    .q     (sync_flags)
  );

  assign oc_s = sync_flags[0];
  assign uv_s = sync_flags[NUM_LIN:1];
  assign ov_s = sync_flags[FLAG_W-1];

  hiccup_ramp #(
    .RAMP_W (RAMP_W)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (por_n),
    .tick      (tick_i),
    .discharge (phase == PH_DISCHARGE),
    .ramp      (ramp_o),
    .at_full   (ramp_full),
    .at_zero   (ramp_zero)
  );

  hiccup_ctrl #(
    .NUM_LIN (NUM_LIN),
    .RETRIES (RETRIES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (por_n),
    .oc_s      (oc_s),
    .uv_s      (uv_s),
    .ov_s      (ov_s),
    .ramp_full (ramp_full),
    .ramp_zero (ramp_zero),
    .phase     (phase),
    .inhibit   (inhibit_o),
    .fault     (fault_o),
    .crowbar   (crowbar_o)
  );

  AST_FAULT_NO_RISE: assert property (@(posedge clk) disable iff (!por_n)
    fault_o |=> (ramp_o <= $past(ramp_o))); // R9
  AST_FAULT_INHIBITS: assert property (@(posedge clk) disable iff (!por_n)
    fault_o |-> inhibit_o); // R9

endmodule

// File: tb/sim_hiccup_supervisor.sv
module sim_hiccup_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int FULL       = 1023;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       oc_flag_i = 1'b0;
  logic [2:0] uv_flag_i = 3'b000;
  logic       ov_flag_i = 1'b0;
  logic       inhibit_o;
  logic [9:0] ramp_o;
  logic       fault_o;
  logic       crowbar_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hiccup_supervisor u0 (
    .clk       (clk),
    .por_n     (por_n),
    .tick_i    (tick_i),
    .oc_flag_i (oc_flag_i),
    .uv_flag_i (uv_flag_i),
    .ov_flag_i (ov_flag_i),
    .inhibit_o (inhibit_o),
    .ramp_o    (ramp_o),
    .fault_o   (fault_o),
    .crowbar_o (crowbar_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // n rising edges, then settle on the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_full();
    int n = 0;
    while (ramp_o != 10'(FULL) && n < 3000) begin
      step(1);
      n++;
    end
    chk("R2 ramp reaches full scale", ramp_o, FULL);
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 1'b0; oc_flag_i = 0; uv_flag_i = 0; ov_flag_i = 0; tick_i = 1;
    step(2);
    chk("R1 inhibit in reset", inhibit_o, 0);
    chk("R1 fault in reset", fault_o, 0);
    chk("R1 crowbar in reset", crowbar_o, 0);
    chk("R1 ramp in reset", ramp_o, 0);
    por_n = 1'b1;
  endtask

  task automatic pulse_oc();
    oc_flag_i = 1'b1;
    step(1);
    oc_flag_i = 1'b0;
  endtask

  task automatic t_ramp();
    do_reset();
    step(1);
    chk("R2 first step", ramp_o, 1);
    tick_i = 0;
    step(20);
    chk("R2 hold without tick", ramp_o, 1);
    tick_i = 1;
    step(10);
    chk("R2 ten ticks", ramp_o, 11);
    wait_full();
    step(5);
    chk("R2 saturate", ramp_o, FULL);
  endtask

  task automatic t_uv();
    int seen = 0;
    do_reset();
    step(100);
    uv_flag_i = 3'b010;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (inhibit_o) seen++;
    end
    uv_flag_i = 3'b000;
    step(3);
    chk("R4 uv blanked below full scale", seen + int'(inhibit_o), 0);
    wait_full();
    step(2);
    uv_flag_i = 3'b100;
    step(1);
    uv_flag_i = 3'b000;
    step(1);
    chk("R5 uv not yet latched at edge 2", inhibit_o, 0);
    step(1);
    chk("R5 uv trips at edge 3", inhibit_o, 1);
    step(1);
    chk("R6 ramp still full at retry edge", ramp_o, FULL);
    step(1);
    chk("R6 ramp discharged", ramp_o, 0);
    step(1);
    chk("R8 inhibit released on restart", inhibit_o, 0);
    step(1);
    chk("R8 ramp counts again", ramp_o, 1);
  endtask

  task automatic t_oc_hold();
    do_reset();
    wait_full();
    oc_flag_i = 1'b1;
    step(2);
    chk("R3 no inhibit at edge 2", inhibit_o, 0);
    step(1);
    chk("R3 inhibit at edge 3", inhibit_o, 1);
    step(2);
    chk("R6 first trip discharges at once", ramp_o, 0);
    step(2);
    chk("R8 restart from zero", ramp_o, 1);
    chk("R7 held trip inhibits again", inhibit_o, 1);
    step(200);
    chk("R7 ramp keeps rising", ramp_o, 201);
    chk("R7 inhibit during rise", inhibit_o, 1);
    wait_full();
    chk("R7 no fault at second full scale", fault_o, 0);
    step(1);
    chk("R7 no fault after second retry", fault_o, 0);
    step(1);
    chk("R7 discharge after full scale", ramp_o, 0);
    wait_full();
    chk("R9 no fault before third retry", fault_o, 0);
    step(1);
    chk("R9 fault on third retry", fault_o, 1);
    step(1);
    chk("R9 ramp discharged on fault", ramp_o, 0);
    oc_flag_i = 1'b0;
    step(40);
    chk("R9 ramp stays zero", ramp_o, 0);
    chk("R9 inhibit held", inhibit_o, 1);
    chk("R11 fault persists", fault_o, 1);
    chk("R9 no crowbar for current fault", crowbar_o, 0);
  endtask

  task automatic t_ov();
    do_reset();
    step(50);
    ov_flag_i = 1'b1;
    step(2);
    chk("R10 no fault at edge 2", fault_o, 0);
    step(1);
    chk("R10 fault at edge 3", fault_o, 1);
    chk("R10 crowbar at edge 3", crowbar_o, 1);
    chk("R10 inhibit with fault", inhibit_o, 1);
    step(1);
    chk("R10 ramp cleared", ramp_o, 0);
    ov_flag_i = 1'b0;
    step(30);
    chk("R11 fault persists after ov", fault_o, 1);
    chk("R11 crowbar persists", crowbar_o, 1);
    chk("R10 ramp held at zero", ramp_o, 0);
  endtask

  task automatic t_persist();
    do_reset();
    for (int k = 0; k < 2; k++) begin
      wait_full();
      pulse_oc();
      step(5);
      chk("R8 recovered after pulse", inhibit_o, 0);
      chk("R11 no fault before third retry", fault_o, 0);
    end
    wait_full();
    pulse_oc();
    step(2);
    chk("R11 trip latched", inhibit_o, 1);
    chk("R11 fault not yet", fault_o, 0);
    step(1);
    chk("R11 count kept across recovery", fault_o, 1);
    do_reset();
    wait_full();
    pulse_oc();
    step(5);
    chk("R11 reset cleared count", fault_o, 0);
    chk("R11 recovered after reset", inhibit_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_ramp();
    t_uv();
    t_oc_hold();
    t_ov();
    t_persist();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule